// File: doc/BRIEF.md
# SPI Register Frame Controller

This block is the serial front end of a register bank in a power-management companion device. A host reaches it over a four-wire SPI link (mode 0, most significant bit first) in fixed 16-bit frames. Each frame carries a 2-bit register address in bits 15:14, a read-select bit in bit 13, a read-only bit in bit 12 and twelve data bits in bits 11:0. The block counts serial clocks while chip-select is low. When chip-select rises, it commits the data to the interrupt enable register only if the count was exactly sixteen, the read-only bit was clear, the address was 01 and the device's operating mode allows writes.

In the same frame the block shifts a reply back to the host. Once the four header bits have arrived it chooses the reply from the read-select bit: the enable register itself, or the enable-feedback word supplied by the surrounding logic. A frame with the wrong clock count is discarded. While the SPI-failure enable is set, a discarded frame raises an interrupt pulse. In the Start-up or Restart mode it asks for a reset instead. All SPI pins pass through two-flop synchronizers, and their edges are detected in the system clock domain.

Top module: `spi_regframe_ctrl`

## Requirements
- R1: After reset the enable register reads 0, the reply driver is disabled (`miso_en`=0) and `wr_done`, `spi_fail_irq` and `spi_rst_req` are all 0.
- R2: A 16-clock frame with address 01 and read-only bit 0, sent in Normal (`op_mode`=2) or Standby (`op_mode`=3), loads frame bits 11:0 into the enable register after chip-select rises. Bit 2 is always stored as 0.
- R3: A frame with read-only bit 12 set leaves the enable register unchanged.
- R4: In any mode other than Normal or Standby, the enable register is not written. The other modes are Start-up=0, Restart=1, Flash=4 and Sleep=5.
- R5: A frame whose address is not 01 writes nothing, and its reply data bits are all 0.
- R6: A frame with fewer or more than 16 clocks writes nothing.
- R7: Reply bits 15:12 are 0. Reply bits 11:0 hold the enable register as it stood when the frame began when bit 13 is 1, and `ie_fb` when bit 13 is 0.
- R8: The reply changes after falling SCLK edges and is read by the host at rising edges. `miso_en` is 1 only while a frame is open, and `miso_data` is 0 whenever `miso_en` is 0.
- R9: A frame with a wrong clock count, in a mode other than Start-up or Restart, gives a one-cycle `spi_fail_irq` pulse if enable bit 8 is 1, and no pulse if bit 8 is 0.
- R10: A frame with a wrong clock count in Start-up or Restart gives a one-cycle `spi_rst_req` pulse whatever bit 8 holds, and no `spi_fail_irq`.
- R11: Each committed write gives exactly one one-cycle `wr_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Chip-select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| op_mode | input | 3 | Operating mode of the device |
| ie_fb | input | 12 | Enable-feedback word returned when bit 13 is 0 |
| miso_data | output | 1 | Serial reply data |
| miso_en | output | 1 | Output enable for the tri-state reply pad |
| ie_reg | output | 12 | Interrupt enable register |
| wr_done | output | 1 | Pulse when a write is committed |
| spi_fail_irq | output | 1 | Pulse when a frame has a wrong clock count |
| spi_rst_req | output | 1 | Pulse requesting a reset after a bad frame in Start-up or Restart |

## Verification
If the bit counter drifts, the error shows in the same frame: the reply slides by one or more bit positions at the host. When chip-select rises, the write is then either dropped or turned into a failure pulse. If the header is decoded wrongly, the reply comes from the wrong register within twelve SCLK periods. A broken write gate changes `ie_reg` about five system cycles after chip-select rises. That change can be seen directly at the port, and again through the read-back in the next frame.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int FRAME_W  = 16;
  localparam int DATA_W   = 12;
  localparam int HDR_W    = 4;
  localparam int RSVD_BIT = 2;
  localparam int SPIF_BIT = 8;
  localparam logic [1:0] IE_ADDR = 2'b01;

  localparam logic [2:0] MODE_STARTUP = 3'd0;
  localparam logic [2:0] MODE_RESTART = 3'd1;
  localparam logic [2:0] MODE_NORMAL  = 3'd2;
  localparam logic [2:0] MODE_STANDBY = 3'd3;

  function automatic logic mode_writable(input logic [2:0] m);
    return (m == MODE_NORMAL) || (m == MODE_STANDBY);
  endfunction

  function automatic logic mode_resets(input logic [2:0] m);
    return (m == MODE_STARTUP) || (m == MODE_RESTART);
  endfunction

  function automatic logic [DATA_W-1:0] clean_ie(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    r = d;
    r[RSVD_BIT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_rf_frame.sv
module spi_rf_frame
  import spi_rf_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_W,
  parameter int DATA_BITS  = DATA_W,
  parameter int HDR_BITS   = HDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_s,
  input  logic                 csn_s,
  input  logic                 mosi_s,
  input  logic [DATA_BITS-1:0] rd_data,
  output logic [1:0]           hdr_addr,
  output logic                 hdr_rrs,
  output logic                 frame_done,
  output logic                 len_ok,
  output logic [1:0]           wr_addr,
  output logic                 wr_ro,
  output logic [DATA_BITS-1:0] wr_data,
  output logic                 miso_data,
  output logic                 frame_active
);
  localparam int CW = $clog2(FRAME_BITS + 2);
  localparam logic [CW-1:0] CNT_MAX  = '1;
  localparam logic [CW-1:0] CNT_HDR  = CW'(HDR_BITS - 1);
  localparam logic [CW-1:0] CNT_DATA = CW'(HDR_BITS);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);

  logic sclk_d, csn_d;
  logic [FRAME_BITS-1:0] rx_q;
  logic [CW-1:0] cnt_q;
  logic [DATA_BITS-1:0] tx_q;
  logic active_q, miso_q;

  wire sclk_rise = sclk_s & ~sclk_d;
  wire sclk_fall = ~sclk_s & sclk_d;
  wire cs_start  = ~csn_s & csn_d;
  wire cs_end    = csn_s & ~csn_d;

  wire [FRAME_BITS-1:0] rx_next = {rx_q[FRAME_BITS-2:0], mosi_s};
  wire hdr_stb  = active_q & sclk_rise & (cnt_q == CNT_HDR);
  wire tx_phase = (cnt_q >= CNT_DATA) && (cnt_q < CNT_FULL);

  assign hdr_addr = rx_next[3:2];
  assign hdr_rrs  = rx_next[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q     <= '0;
      cnt_q    <= '0;
      tx_q     <= '0;
      active_q <= 1'b0;
      miso_q   <= 1'b0;
    end else if (cs_start) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
      miso_q   <= 1'b0;
      tx_q     <= '0;
    end else if (cs_end) begin
      active_q <= 1'b0;
      miso_q   <= 1'b0;
    end else if (active_q) begin
      if (sclk_rise) begin
        rx_q <= rx_next;
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (hdr_stb) tx_q <= rd_data;
      end else if (sclk_fall && tx_phase) begin
        miso_q <= tx_q[DATA_BITS-1];
        tx_q   <= {tx_q[DATA_BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_done <= 1'b0;
      len_ok     <= 1'b0;
      wr_addr    <= '0;
      wr_ro      <= 1'b0;
      wr_data    <= '0;
    end else begin
      frame_done <= cs_end & active_q;
      if (cs_end && active_q) begin
        len_ok  <= (cnt_q == CNT_FULL);
        wr_addr <= rx_q[FRAME_BITS-1 -: 2];
        wr_ro   <= rx_q[DATA_BITS];
        wr_data <= rx_q[DATA_BITS-1:0];
      end
    end
  end

  assign miso_data    = miso_q;
  assign frame_active = active_q;
endmodule

// File: rtl/spi_rf_ie.sv
module spi_rf_ie
  import spi_rf_pkg::*;
#(
  parameter int DATA_BITS = DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_done,
  input  logic                 len_ok,
  input  logic [1:0]           wr_addr,
  input  logic                 wr_ro,
  input  logic [DATA_BITS-1:0] wr_data,
  input  logic [2:0]           op_mode,
  output logic [DATA_BITS-1:0] ie_q,
  output logic                 wr_done,
  output logic                 fail_irq,
  output logic                 rst_req
);
  wire write_ok = len_ok && (wr_addr == IE_ADDR) && !wr_ro && mode_writable(op_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q     <= '0;
      wr_done  <= 1'b0;
      fail_irq <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      wr_done  <= 1'b0;
      fail_irq <= 1'b0;
      rst_req  <= 1'b0;
      if (frame_done) begin
        if (len_ok) begin
          if (write_ok) begin
            ie_q    <= clean_ie(wr_data);
            wr_done <= 1'b1;
          end
        end else if (mode_resets(op_mode)) begin
          rst_req <= 1'b1;
        end else if (ie_q[SPIF_BIT]) begin
          fail_irq <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_regframe_ctrl.sv
module spi_regframe_ctrl
  import spi_rf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  input  logic [2:0]        op_mode,
  input  logic [DATA_W-1:0] ie_fb,
  output logic              miso_data,
  output logic              miso_en,
  output logic [DATA_W-1:0] ie_reg,
  output logic              wr_done,
  output logic              spi_fail_irq,
  output logic              spi_rst_req
);
  logic [2:0] pins_s;
  logic sclk_s, csn_s, mosi_s;
  logic [1:0] hdr_addr, wr_addr;
  logic hdr_rrs, wr_ro;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic frame_done, len_ok;

  spi_rf_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sclk, spi_csn, spi_mosi}), .q(pins_s)
  );
  assign {sclk_s, csn_s, mosi_s} = pins_s;

  always_comb begin
    if (hdr_addr != IE_ADDR) rd_data = '0;
    else if (hdr_rrs)        rd_data = ie_reg;
    else                     rd_data = ie_fb;
  end

  spi_rf_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .csn_s(csn_s), .mosi_s(mosi_s),
    .rd_data(rd_data),
    .hdr_addr(hdr_addr), .hdr_rrs(hdr_rrs),
    .frame_done(frame_done), .len_ok(len_ok),
    .wr_addr(wr_addr), .wr_ro(wr_ro), .wr_data(wr_data),
    .miso_data(miso_data), .frame_active(miso_en)
  );

  spi_rf_ie u_ie (
    .clk(clk), .rst_n(rst_n),
    .frame_done(frame_done), .len_ok(len_ok),
    .wr_addr(wr_addr), .wr_ro(wr_ro), .wr_data(wr_data),
    .op_mode(op_mode),
    .ie_q(ie_reg), .wr_done(wr_done),
    .fail_irq(spi_fail_irq), .rst_req(spi_rst_req)
  );
endmodule

// File: rtl/spi_regframe_sva.sv
module spi_regframe_sva
  import spi_rf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_mode,
  input logic [DATA_W-1:0] ie_reg,
  input logic              wr_done,
  input logic              spi_fail_irq,
  input logic              spi_rst_req,
  input logic              miso_data,
  input logic              miso_en,
  input logic              frame_done,
  input logic              len_ok
);
  AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ie_reg[RSVD_BIT] == 1'b0); // R2
  AST_IE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ie_reg) |-> wr_done); // R3
  AST_WRITE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> ($past(op_mode) == MODE_NORMAL || $past(op_mode) == MODE_STANDBY)); // R4
  AST_WRITE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> $past(frame_done && len_ok)); // R6
  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_en |-> !miso_data); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_fail_irq |-> $past(frame_done && !len_ok && ie_reg[SPIF_BIT])); // R9
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_rst_req |-> $past(frame_done && !len_ok &&
                          (op_mode == MODE_STARTUP || op_mode == MODE_RESTART))); // R10
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !(spi_rst_req && spi_fail_irq)); // R10
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done); // R11
endmodule

bind spi_regframe_ctrl spi_regframe_sva u_sva (
  .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .ie_reg(ie_reg),
  .wr_done(wr_done), .spi_fail_irq(spi_fail_irq), .spi_rst_req(spi_rst_req),
  .miso_data(miso_data), .miso_en(miso_en),
  .frame_done(frame_done), .len_ok(len_ok)
);

// File: tb/spi_regframe_ctrl_tb.sv
module spi_regframe_ctrl_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic [2:0] mode = 3'd2;
  logic [11:0] fb = 12'h000;
  logic miso_data, miso_en, wr_done, fail_irq, rst_req;
  logic [11:0] ie_reg;

  int checks = 0, errors = 0;
  int n_wr = 0, n_irq = 0, n_rst = 0;
  logic [15:0] reply;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_regframe_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
    .op_mode(mode), .ie_fb(fb), .miso_data(miso_data), .miso_en(miso_en),
    .ie_reg(ie_reg), .wr_done(wr_done), .spi_fail_irq(fail_irq), .spi_rst_req(rst_req)
  );

  always @(negedge clk) if (rst_n) begin
    if (wr_done)  n_wr++;
    if (fail_irq) n_irq++;
    if (rst_req)  n_rst++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mk(input logic [1:0] a, input logic rrs,
                                     input logic ro, input logic [11:0] d);
    return {a, rrs, ro, d};
  endfunction

  task automatic xfer(input int nclk, input logic [15:0] frame);
    reply = '0;
    @(negedge clk); csn = 1'b0;
    wait_cyc(HALF);
    checks++;
    if (miso_en !== 1'b1) begin errors++; $display("FAIL R8: miso_en actual %b expected 1", miso_en); end
    for (int i = 0; i < nclk; i++) begin
      mosi = (i < 16) ? frame[15-i] : 1'b0;
      wait_cyc(HALF);
      if (i < 16) reply[15-i] = miso_data;
      sclk = 1'b1;
      wait_cyc(HALF);
      sclk = 1'b0;
    end
    wait_cyc(HALF);
    csn = 1'b1;
    wait_cyc(12);
  endtask

  task automatic t_reset;
    check("R1 ie_reg", ie_reg, 0);
    check("R1 miso_en", miso_en, 0);
    check("R1 pulses", {wr_done, fail_irq, rst_req}, 0);
  endtask

  task automatic t_write_normal;
    mode = 3'd2;
    xfer(16, mk(2'b01, 1'b1, 1'b0, 12'hFFF));
    check("R2 ie after write, bit2 cleared", ie_reg, 12'hFFB);
    check("R7 reply holds old value", reply, 16'h0000);
    check("R11 one wr_done", n_wr, 1);
    check("R8 miso_en after frame", miso_en, 0);
  endtask

  task automatic t_read_only;
    xfer(16, mk(2'b01, 1'b1, 1'b1, 12'h000));
    check("R7 reply of enable reg", reply, 16'h0FFB);
    check("R3 read-only keeps ie", ie_reg, 12'hFFB);
    fb = 12'h5A5;
    xfer(16, mk(2'b01, 1'b0, 1'b1, 12'h000));
    check("R7 reply of feedback", reply, 16'h05A5);
    check("R11 no extra wr_done", n_wr, 1);
  endtask

  task automatic t_write_standby;
    mode = 3'd3;
    xfer(16, mk(2'b01, 1'b1, 1'b0, 12'h12F));
    check("R2 standby write", ie_reg, 12'h12B);
    check("R7 reply before write", reply, 16'h0FFB);
  endtask

  task automatic t_mode_block;
    mode = 3'd0;
    xfer(16, mk(2'b01, 1'b1, 1'b0, 12'h000));
    check("R4 startup no write", ie_reg, 12'h12B);
    mode = 3'd4;
    xfer(16, mk(2'b01, 1'b1, 1'b0, 12'h000));
    check("R4 flash no write", ie_reg, 12'h12B);
    mode = 3'd5;
    xfer(16, mk(2'b01, 1'b1, 1'b0, 12'h000));
    check("R4 sleep no write", ie_reg, 12'h12B);
    check("R10 no reset on good frame", n_rst, 0);
  endtask

  task automatic t_other_addr;
    mode = 3'd2;
    xfer(16, mk(2'b10, 1'b1, 1'b0, 12'h000));
    check("R5 other address no write", ie_reg, 12'h12B);
    check("R5 other address reply zero", reply, 16'h0000);
  endtask

  task automatic t_bad_len;
    mode = 3'd2;
    xfer(15, mk(2'b01, 1'b1, 1'b0, 12'h000));
    check("R6 short frame no write", ie_reg, 12'h12B);
    check("R9 irq on short frame", n_irq, 1);
    xfer(17, mk(2'b01, 1'b1, 1'b0, 12'h000));
    check("R6 long frame no write", ie_reg, 12'h12B);
    check("R9 irq on long frame", n_irq, 2);
    xfer(16, mk(2'b01, 1'b1, 1'b0, 12'h001));
    check("R2 write with bit8 clear", ie_reg, 12'h001);
    xfer(15, mk(2'b01, 1'b1, 1'b0, 12'h000));
    check("R9 no irq when disabled", n_irq, 2);
    check("R11 wr_done count", n_wr, 3);
  endtask

  task automatic t_reset_req;
    mode = 3'd1;
    xfer(14, mk(2'b01, 1'b1, 1'b0, 12'h000));
    check("R10 restart reset request", n_rst, 1);
    mode = 3'd2;
    xfer(16, mk(2'b01, 1'b1, 1'b0, 12'h100));
    mode = 3'd0;
    xfer(15, mk(2'b01, 1'b1, 1'b0, 12'h000));
    check("R10 startup reset request", n_rst, 2);
    check("R10 no irq in startup", n_irq, 2);
    check("R6 ie kept", ie_reg, 12'h100);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset;
    t_write_normal;
    t_read_only;
    t_write_standby;
    t_mode_block;
    t_other_addr;
    t_bad_len;
    t_reset_req;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule